// File: doc/BRIEF.md
# AGC Attenuation Code Controller

This block is the digital half of an automatic gain control loop. An analog level detector and comparator outside the block compare the loop output with a reference. They deliver one flag: the output is above the reference, or it is not. On every qualified update tick the block moves an 8-bit attenuation code by a single step. The code drives a logarithmic attenuator whose step is 0.375 dB per code. The feedback is negative: a loud output raises the attenuation, and a quiet one lowers it.

The code is held inside the attenuator's usable range of 0 to 239, because codes of 240 and above silence the attenuator. This keeps the input/output relation well defined when the signal lies outside the loop's dynamic range. Two flags report when the code rests on either end stop. A single-cycle write strobe tells the attenuator's register interface that a new code is present. An enable input freezes the loop without losing the current code.

Top module: `agc_code_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no qualified tick, code_o is 0, wr_stb_o is 0, at_min_o is 1 and at_max_o is 0. Reset takes effect without a clock edge.
- R2: On a clock edge where tick_i, en_i and level_high_i are all 1 and code_o is below 239, code_o becomes the old value plus one.
- R3: On a clock edge where tick_i and en_i are 1, level_high_i is 0 and code_o is above 0, code_o becomes the old value minus one.
- R4: On a clock edge where tick_i is 0 or en_i is 0, code_o keeps its value, whatever level_high_i is.
- R5: A count-up request at code 239 leaves code_o at 239. The code never wraps and never enters the mute range.
- R6: A count-down request at code 0 leaves code_o at 0. The code never wraps to the top.
- R7: at_max_o is 1 exactly while code_o equals 239, and at_min_o is 1 exactly while code_o equals 0.
- R8: wr_stb_o is 1 for exactly the one cycle that follows a clock edge at which code_o changed, so it coincides with the first cycle of the new code. In every other cycle it is 0.
- R9: Between two consecutive clock edges code_o changes by at most one, and it stays at or below 239 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Update tick, one cycle wide, qualifies a loop step |
| level_high_i | input | 1 | Comparator result: 1 means the output level is above the reference |
| en_i | input | 1 | Loop enable; 0 freezes the code |
| code_o | output | 8 | Attenuation code, 0 to 239 |
| wr_stb_o | output | 1 | One-cycle strobe that marks a new code |
| at_max_o | output | 1 | Code rests on the upper end stop (239) |
| at_min_o | output | 1 | Code rests on the lower end stop (0) |

## Verification
A corrupted code register shows at code_o in the cycle right after the faulty edge. It appears as a jump of more than one step, a move without a qualified tick, or a wrap through the end stops into the mute codes. A decision path that has lost its limit guard is exposed the first time the code is driven against either end stop: a 239-to-240 or a 0-to-255 transition, together with the wrong limit flag. A strobe register that is out of step with the code shows within one cycle, either as a pulse without a code change or as a change without a pulse.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned CODE_W_DEF   = 8;
  localparam int unsigned TOP_CODE_DEF = 239;
endpackage

// File: rtl/agc_limit_det.sv
module agc_limit_det #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned TOP_CODE = 239
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              at_max_o,
  output logic              at_min_o
);
  localparam logic [CODE_W-1:0] TopVal = TOP_CODE[CODE_W-1:0];

  assign at_max_o = (code_i == TopVal);
  assign at_min_o = (code_i == '0);
endmodule

// File: rtl/agc_step_dec.sv
module agc_step_dec
  import agc_pkg::*;
(
  input  logic  tick_i,
  input  logic  en_i,
  input  logic  level_high_i,
  input  logic  at_max_i,
  input  logic  at_min_i,
  output step_e step_o
);
  // negative feedback: loud output -> more attenuation; end stops suppress the move
  always_comb begin
    step_o = STEP_HOLD;
    if (tick_i && en_i) begin
      if (level_high_i) begin
        if (!at_max_i) step_o = STEP_UP;
      end else begin
        if (!at_min_i) step_o = STEP_DOWN;
      end
    end
  end
endmodule

// File: rtl/agc_sat_counter.sv
module agc_sat_counter
  import agc_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              moved_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else begin
      unique case (step_i)
        STEP_UP:   code_q <= code_q + 1'b1;
        STEP_DOWN: code_q <= code_q - 1'b1;
        default:   code_q <= code_q;
      endcase
    end
  end

  assign code_o  = code_q;
  assign moved_o = (step_i != STEP_HOLD);
endmodule

// File: rtl/agc_code_ctrl.sv
module agc_code_ctrl
  import agc_pkg::*;
#(
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned TOP_CODE = TOP_CODE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              level_high_i,
  input  logic              en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              wr_stb_o,
  output logic              at_max_o,
  output logic              at_min_o
);
  step_e             step;
  logic [CODE_W-1:0] code;
  logic              moved;
  logic              at_max, at_min;
  logic              stb_q;

  agc_limit_det #(
    .CODE_W  (CODE_W),
    .TOP_CODE(TOP_CODE)
  ) u_limit (
    .code_i  (code),
    .at_max_o(at_max),
    .at_min_o(at_min)
  );

  agc_step_dec u_dec (
    .tick_i      (tick_i),
    .en_i        (en_i),
    .level_high_i(level_high_i),
    .at_max_i    (at_max),
    .at_min_i    (at_min),
    .step_o      (step)
  );

  agc_sat_counter #(
    .CODE_W(CODE_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .code_o (code),
    .moved_o(moved)
  );

  // strobe lines up with the first cycle of the new code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= moved;
  end

  assign code_o   = code;
  assign wr_stb_o = stb_q;
  assign at_max_o = at_max;
  assign at_min_o = at_min;
endmodule

// File: rtl/agc_code_ctrl_chk.sv
module agc_code_ctrl_chk #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned TOP_CODE = 239
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              level_high_i,
  input logic              en_i,
  input logic [CODE_W-1:0] code_o,
  input logic              wr_stb_o,
  input logic              at_max_o,
  input logic              at_min_o
);
  localparam logic [CODE_W-1:0] TopVal = TOP_CODE[CODE_W-1:0];

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && level_high_i && code_o < TopVal) |=> code_o == $past(code_o) + 1'b1);

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !level_high_i && code_o != '0) |=> code_o == $past(code_o) - 1'b1);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || !en_i) |=> $stable(code_o));

  p_top_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && level_high_i && code_o == TopVal) |=> code_o == TopVal);

  p_bottom_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !level_high_i && code_o == '0) |=> code_o == '0);

  p_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max_o == (code_o == TopVal)) && (at_min_o == (code_o == '0)));

  p_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> wr_stb_o == (code_o != $past(code_o)));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= TopVal);

  p_single_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (code_o == $past(code_o)) || (code_o == $past(code_o) + 1'b1)
             || (code_o == $past(code_o) - 1'b1));
endmodule

bind agc_code_ctrl agc_code_ctrl_chk #(
  .CODE_W  (CODE_W),
  .TOP_CODE(TOP_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .level_high_i(level_high_i),
  .en_i        (en_i),
  .code_o      (code_o),
  .wr_stb_o    (wr_stb_o),
  .at_max_o    (at_max_o),
  .at_min_o    (at_min_o)
);

// File: tb/agc_code_ctrl_test.sv
`timescale 1ns/1ps
module agc_code_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       lvl_hi = 1'b0;
  logic       en = 1'b0;
  logic [7:0] code;
  logic       stb, at_max, at_min;

  int n_chk = 0;
  int n_fail = 0;
  int exp_code = 0;
  bit done = 0;

  always #10 clk = ~clk;

  agc_code_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .level_high_i(lvl_hi),
    .en_i        (en),
    .code_o      (code),
    .wr_stb_o    (stb),
    .at_max_o    (at_max),
    .at_min_o    (at_min)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // one cycle of stimulus; checks code, strobe and flags after the edge
  task automatic step(input bit t, input bit e, input bit h, input string req);
    int prev;
    @(negedge clk);
    tick = t; en = e; lvl_hi = h;
    prev = exp_code;
    if (t && e) begin
      if (h && exp_code < 239) exp_code++;
      else if (!h && exp_code > 0) exp_code--;
    end
    @(posedge clk);
    #1;
    chk(code, exp_code, {req, " code"});
    chk(stb, (exp_code != prev) ? 1 : 0, "R8 strobe");
    chk(at_max, (exp_code == 239) ? 1 : 0, "R7 at_max");
    chk(at_min, (exp_code == 0) ? 1 : 0, "R7 at_min");
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_code = 0;
    chk(code, 0, "R1 code in reset");
    chk(stb, 0, "R1 strobe in reset");
    chk(at_min, 1, "R1 at_min in reset");
    chk(at_max, 0, "R1 at_max in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 1, "R1 after release");
  endtask

  task automatic t_up;
    for (int i = 0; i < 5; i++) step(1, 1, 1, "R2 up");
    chk(code, 5, "R2 five steps");
  endtask

  task automatic t_down;
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R3 down");
    chk(code, 2, "R3 three down");
  endtask

  task automatic t_hold;
    step(0, 1, 1, "R4 no tick high");
    step(0, 1, 0, "R4 no tick low");
    step(1, 0, 1, "R4 disabled high");
    step(1, 0, 0, "R4 disabled low");
    step(0, 0, 1, "R4 idle");
    chk(code, 2, "R4 code kept");
  endtask

  task automatic t_top;
    while (exp_code < 239) step(1, 1, 1, "R9 climb");
    chk(code, 239, "R5 reached top");
    step(1, 1, 1, "R5 top stop");
    step(1, 1, 1, "R5 top stop again");
    chk(code, 239, "R5 no wrap");
    step(1, 1, 0, "R3 leave top");
    chk(code, 238, "R3 238");
    step(1, 1, 1, "R2 back to top");
  endtask

  task automatic t_bottom;
    while (exp_code > 0) step(1, 1, 0, "R9 descend");
    chk(code, 0, "R6 reached bottom");
    step(1, 1, 0, "R6 bottom stop");
    step(1, 1, 0, "R6 bottom stop again");
    chk(code, 0, "R6 no wrap");
  endtask

  task automatic t_alternate;
    for (int i = 0; i < 8; i++) step(1, 1, (i % 2) == 0, "R2 R3 alternate");
    chk(code, 0, "R8 alternate net zero");
    step(1, 1, 1, "R2 up");
    step(0, 1, 1, "R8 strobe drops");
  endtask

  task automatic t_async_reset;
    step(1, 1, 1, "R2 up before reset");
    step(1, 1, 1, "R2 up before reset");
    t_reset();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(code, 0, "R1 code at start");
    chk(stb, 0, "R1 strobe at start");
    rst_n = 1'b1;
    t_reset();
    t_up();
    t_down();
    t_hold();
    t_top();
    t_bottom();
    t_alternate();
    t_async_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule